// File: doc/BRIEF.md
# Pairwise Tree Reduction Sequencer

This block adds up N partial values of W bits each, where N is a parameter that need not be a power of two. A start pulse loads all N values in parallel into an internal register array. The block then works through synchronized rounds. In each round the lower half of the live entries absorb their partners from the upper half, and the total ends up in entry 0.

When the live count is odd, the lone middle element is folded into entry 0 before the count is halved, so no value is lost. Each round takes exactly one clock. All additions in a round read the register values from before that round, which gives a clean barrier between steps. At the end a one-cycle done pulse marks the result. The total is held on the sum output until the next reduction completes. A round counter shows how many rounds have run.

Top module: `tree_reduce`

## Requirements
- R1: After reset, sum_out is 0, done is 0 and round_cnt is 0.
- R2: A start pulse seen while the block is idle loads entry i from load_data bits [i*W +: W] for every i below N, sets the live count to N and clears round_cnt to 0. The done-high cycle counts as idle.
- R3: In a round whose live count is odd and above 1, entry 0 also adds the entry at index count-1, using its value from before the round.
- R4: In each round the live count becomes floor(count/2). Every entry below that new count adds the entry at its index plus the new count. All additions read values from before the round, and each round takes one clock.
- R5: done goes high for exactly one cycle, ROUNDS = floor(log2 N) clock edges after the edge that accepted start. In that cycle sum_out equals the sum of all N loaded values.
- R6: round_cnt increases by one per round, equals ROUNDS while done is high, and then holds until the next accepted start.
- R7: A start pulse seen while a reduction is running is ignored. This includes the edge of the final round. It changes neither the result, nor the round count, nor the timing, and no further done pulse follows.
- R8: Additions wrap modulo 2^W (two's complement), so the result is the true sum modulo 2^W.
- R9: sum_out changes only at the edge where done rises. Between results it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a reduction; sampled only when idle |
| load_data | input | N*W | N packed partial values, entry i at [i*W +: W] |
| sum_out | output | W | Last completed total |
| done | output | 1 | One-cycle pulse when a total is ready |
| round_cnt | output | $clog2(N+1) | Rounds run in the current or last reduction |

## Verification
Two events can fall in one cycle: the final round completing (done rising) and a new start arriving. The bench raises start on the edge of the final round and checks that it is dropped: the sum matches the first data set and no second done pulse appears. It also raises start during the done-high cycle and checks that this start is accepted and yields the new data's total ROUNDS edges later. Start is also poked during earlier rounds, with different data on load_data, and the bench confirms the result and round count are untouched.

// File: rtl/tree_reduce.sv
module tree_reduce #(
  parameter int N = 100,
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [N*W-1:0]   load_data,
  output logic [W-1:0]     sum_out,
  output logic             done,
  output logic [$clog2(N+1)-1:0] round_cnt
);

  localparam int CW = $clog2(N+1);

  function automatic int rounds_for(input int n);
    int c, r;
    c = n;
    r = 0;
    while (c > 1) begin
      c = c / 2;
      r = r + 1;
    end
    return r;
  endfunction

  localparam int ROUNDS = rounds_for(N);

  logic [W-1:0]  ent [N];
  logic [W-1:0]  nxt [N];
  logic [CW-1:0] cnt;
  logic [CW-1:0] half;
  logic          busy;
  logic          accept;
  logic          step;

  assign half   = cnt >> 1;
  assign accept = !busy && start;
  assign step   = busy && (cnt > CW'(1));

  always_comb begin
    for (int i = 0; i < N; i++) begin
      nxt[i] = ent[i];
      if (i < int'(half))
        nxt[i] = ent[i] + ent[i + int'(half)];
    end
    if (cnt[0] && cnt > CW'(1))
      nxt[0] = nxt[0] + ent[int'(cnt) - 1];
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      for (int i = 0; i < N; i++)
        ent[i] <= load_data[i*W +: W];
    end else if (step) begin
      for (int i = 0; i < N; i++)
        ent[i] <= nxt[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      round_cnt <= '0;
      sum_out   <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy      <= 1'b1;
        cnt       <= CW'(N);
        round_cnt <= '0;
      end else if (busy && !step) begin
        busy    <= 1'b0;
        done    <= 1'b1;
        sum_out <= ent[0];
      end else if (step) begin
        cnt       <= half;
        round_cnt <= round_cnt + 1'b1;
        if (half == CW'(1)) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          sum_out <= nxt[0];
        end
      end
    end
  end

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_rounds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> round_cnt == CW'(ROUNDS));

  p_round_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    round_cnt <= CW'(ROUNDS));

  p_sum_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(sum_out));

  p_halving_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cnt == $past(half));

  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && step) |=> round_cnt == $past(round_cnt) + 1'b1);

  p_idle_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !done);

endmodule

// File: tb/sim_tree_reduce.sv
`timescale 1ns/1ps
module sim_tree_reduce;
  localparam int N  = 13;
  localparam int W  = 8;
  localparam int CW = $clog2(N+1);

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [N*W-1:0] load_data = '0;
  logic [W-1:0] sum_out;
  logic done;
  logic [CW-1:0] round_cnt;

  int total = 0;
  int bad = 0;
  int rounds;

  always #2.5 clk = ~clk;

  tree_reduce #(.N(N), .W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .load_data(load_data),
    .sum_out(sum_out), .done(done), .round_cnt(round_cnt)
  );

  localparam logic [15:0] VEC [5] = '{16'hFF00, 16'h0101, 16'h8011, 16'h0000, 16'h7F3D};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [N*W-1:0] pack(input logic [7:0] b, input logic [7:0] s);
    logic [N*W-1:0] p;
    for (int i = 0; i < N; i++) p[i*W +: W] = W'(b + s*i);
    return p;
  endfunction

  function automatic int expect_sum(input logic [N*W-1:0] p);
    int e = 0;
    for (int i = 0; i < N; i++) e += int'(p[i*W +: W]);
    return e % 256;
  endfunction

  task automatic run(input logic [N*W-1:0] p, input bit poke);
    int e = expect_sum(p);
    int prev;
    @(negedge clk); load_data = p; start = 1;
    @(negedge clk);
    for (int r = 1; r <= rounds; r++) begin
      if (poke) begin start = 1; load_data = ~p; end else start = 0;
      @(negedge clk);
      chk(done == (r == rounds), poke ? "R7 done timing" : "R5 done timing", done, r == rounds);
      if (r < rounds) chk(round_cnt == CW'(r), "R6 round step", round_cnt, r);
    end
    start = 0;
    chk(sum_out == W'(e), poke ? "R7 sum" : "R5/R8 sum", sum_out, e);
    chk(round_cnt == CW'(rounds), "R6 final rounds", round_cnt, rounds);
    prev = sum_out;
    for (int k = 0; k < rounds + 2; k++) begin
      @(negedge clk);
      chk(done == 0, "R5/R7 no extra done", done, 0);
      chk(sum_out == W'(prev), "R9 sum hold", sum_out, prev);
    end
    chk(round_cnt == CW'(rounds), "R6 hold", round_cnt, rounds);
  endtask

  initial begin
    logic [N*W-1:0] a, b;
    rounds = 0;
    for (int c = N; c > 1; c = c / 2) rounds++;
    #12;
    chk(sum_out == 0, "R1 sum", sum_out, 0);
    chk(done == 0, "R1 done", done, 0);
    chk(round_cnt == 0, "R1 rounds", round_cnt, 0);
    @(negedge clk); rst_n = 1;
    for (int v = 0; v < 5; v++) run(pack(VEC[v][15:8], VEC[v][7:0]), 1'b0);
    // R7: start poked during every round, including the final edge
    run(pack(8'h21, 8'h05), 1'b1);
    // R8: all 0xFF wraps: 13*255 mod 256 = 243
    run({N{8'hFF}}, 1'b0);
    chk(sum_out == 8'd243, "R8 wrap", sum_out, 243);
    // R2: start in the done-high cycle is accepted
    a = pack(8'h03, 8'h07);
    b = pack(8'h40, 8'h02);
    @(negedge clk); load_data = a; start = 1;
    @(negedge clk); start = 0;
    for (int r = 1; r <= rounds; r++) begin
      if (r == rounds) begin start = 1; load_data = b; end
      @(negedge clk);
    end
    chk(done == 1, "R5 first done", done, 1);
    chk(sum_out == W'(expect_sum(a)), "R5 first sum", sum_out, expect_sum(a));
    start = 1; load_data = b;
    @(negedge clk); start = 0;
    chk(round_cnt == 0, "R2 counter cleared", round_cnt, 0);
    for (int r = 1; r <= rounds; r++) @(negedge clk);
    chk(done == 1, "R2 back-to-back done", done, 1);
    chk(sum_out == W'(expect_sum(b)), "R2/R3/R4 back-to-back sum", sum_out, expect_sum(b));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    bad++;
    total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule